// File: doc/BRIEF.md
# Four-Bit Carry-Skip Adder Slice with Early Second Carry

This block adds two unsigned operands and a carry-in and produces a sum and a carry-out, with no clock and no state. It is built from 4-bit slices. Inside a slice, the carry into bit 1 does not wait for the bit-0 cell. It is formed straight from the bit-0 generate and propagate terms and the slice carry-in. Bits 2 and 3 then ripple from that early carry.

A 2:1 select picks each slice's carry-out. When all four bit positions propagate, the slice carry-in goes straight to the carry-out. Otherwise the carry rippled out of bit 3 is used. A parameterized wrapper chains slices, each slice's carry-out feeding the next slice's carry-in, to reach any width that is a multiple of four.

The datapath is purely combinational, so it has no valid/ready handshake and no back-pressure. The result is valid as soon as the operands settle. A caller that needs a stream interface registers the operands and the result around it.

Top module: `csk_adder`

## Requirements
- R1: For every 4-bit slice, {carry-out, sum} equals a + b + carry-in as unsigned integers. Zero operands with zero carry-in give a zero sum and zero carry-out.
- R2: The carry into bit 1 of a slice is (a[0] AND b[0]) OR ((a[0] XOR b[0]) AND carry-in). Sum bit 1 is therefore a[1] XOR b[1] XOR that carry.
- R3: When a XOR b is all ones in a slice (every bit propagates), the slice carry-out equals the slice carry-in, for both carry-in values.
- R4: When at least one bit of a slice does not propagate, the slice carry-out is bit 4 of a + b + carry-in, which is the carry rippled out of bit 3.
- R5: With WIDTH a multiple of 4, the chained adder gives sum_o = (a_i + b_i + c_i) mod 2^WIDTH and c_o = bit WIDTH of that sum. Slice k takes its carry-in from the carry-out of slice k-1, and slice 0 takes c_i.
- R6: For a = 4'b1001, b = 4'b1001 and carry-in 0, a single slice gives sum 4'b0010 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| c_i | input | 1 | Carry into the lowest slice |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| c_o | output | 1 | Carry out of the highest slice |

## Verification
The bench builds two copies of the adder. One has WIDTH = 4, a single slice, so all 512 operand and carry combinations can be swept. That sweep covers both skip cases and every early-carry case. The other has WIDTH = 64, sixteen chained slices, and takes directed patterns and pseudo-random operands. These include carries that are generated in one slice and skipped across many propagating slices above it.

// File: rtl/csk_pkg.sv
package csk_pkg;
  localparam int unsigned SLICE_W = 4;
endpackage

// File: rtl/csk_bitcell.sv
module csk_bitcell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic p_o,
  output logic g_o
);
  always_comb begin
    p_o = a_i ^ b_i;
    g_o = a_i & b_i;
    s_o = p_o ^ c_i;
  end
endmodule

// File: rtl/csk_skip_mux.sv
module csk_skip_mux #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic         cin_i,
  input  logic         ripple_i,
  output logic         cout_o
);
  logic sel;
  always_comb begin
    sel    = &p_i;
    cout_o = sel ? cin_i : ripple_i;
  end
endmodule

// File: rtl/csk_slice.sv
module csk_slice
  import csk_pkg::*;
(
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);
  logic [SLICE_W-1:0] p, g;
  logic [SLICE_W:0]   cy;

  // carry into bit 0 is the slice input; carry into bit 1 is formed early
  assign cy[0] = cin_i;
  assign cy[1] = g[0] | (p[0] & cin_i);

  genvar i;
  generate
    for (i = 0; i < SLICE_W; i++) begin : g_bit
      csk_bitcell u_cell (
        .a_i(a_i[i]), .b_i(b_i[i]), .c_i(cy[i]),
        .s_o(sum_o[i]), .p_o(p[i]), .g_o(g[i])
      );
    end
    for (i = 2; i <= SLICE_W; i++) begin : g_rip
      assign cy[i] = g[i-1] | (p[i-1] & cy[i-1]);
    end
  endgenerate

  csk_skip_mux #(.N(SLICE_W)) u_mux (
    .p_i(p), .cin_i(cin_i), .ripple_i(cy[SLICE_W]), .cout_o(cout_o)
  );

  logic [SLICE_W:0] ref_sum;
  logic [1:0]       ref_b0;
  always_comb begin
    ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i};
    ref_b0  = {1'b0, a_i[0]} + {1'b0, b_i[0]} + {1'b0, cin_i};
    p_slice_sum_r1: assert ({cout_o, sum_o} == ref_sum);
    p_early_carry_r2: assert (cy[1] == ref_b0[1]);
    if ((a_i ^ b_i) == {SLICE_W{1'b1}}) begin
      p_skip_passes_cin_r3: assert (cout_o == cin_i);
    end else begin
      p_ripple_out_r4: assert (cout_o == ref_sum[SLICE_W]);
    end
  end
endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);
  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  logic [NSLICE:0] chain;
  assign chain[0] = c_i;

  genvar k;
  generate
    for (k = 0; k < NSLICE; k++) begin : g_slice
      csk_slice u_slice (
        .a_i  (a_i[k*SLICE_W +: SLICE_W]),
        .b_i  (b_i[k*SLICE_W +: SLICE_W]),
        .cin_i(chain[k]),
        .sum_o(sum_o[k*SLICE_W +: SLICE_W]),
        .cout_o(chain[k+1])
      );
    end
  endgenerate

  assign c_o = chain[NSLICE];

  logic [WIDTH:0] ref_total;
  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
    p_chain_sum_r5: assert ({c_o, sum_o} == ref_total);
  end
endmodule

// File: tb/sim_csk_adder.sv
module sim_csk_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] a0, b0, s0;
  logic        c0, co0;
  logic [3:0]  a4, b4, s4;
  logic        c4, co4;

  csk_adder #(.WIDTH(64)) u0 (.a_i(a0), .b_i(b0), .c_i(c0), .sum_o(s0), .c_o(co0));
  csk_adder #(.WIDTH(4))  u4 (.a_i(a4), .b_i(b4), .c_i(c4), .sum_o(s4), .c_o(co4));

  // fields: [13:10] a, [9:6] b, [5] cin, [4:1] sum, [0] cout
  localparam logic [13:0] VEC [8] = '{
    14'b1001_1001_0_0010_1,
    14'b1111_0000_1_0000_1,
    14'b1111_0000_0_1111_0,
    14'b0101_1010_1_0000_1,
    14'b0101_1010_0_1111_0,
    14'b0000_0000_0_0000_0,
    14'b1111_1111_1_1111_1,
    14'b0111_0001_0_1000_0
  };

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run64(input logic [63:0] a, input logic [63:0] b, input logic c, input string tag);
    logic [64:0] e;
    @(posedge clk);
    a0 = a; b0 = b; c0 = c;
    e = {1'b0, a} + {1'b0, b} + {64'd0, c};
    @(negedge clk);
    chk({co0, s0} == e, tag, {co0, s0}, e);
  endtask

  initial begin
    a0 = '0; b0 = '0; c0 = 1'b0;
    a4 = '0; b4 = '0; c4 = 1'b0;
    @(negedge clk);
    // R1: zero in gives zero out
    chk({co4, s4} == 5'd0, "R1 zero", {60'd0, co4, s4}, 65'd0);
    chk({co0, s0} == 65'd0, "R5 zero", {co0, s0}, 65'd0);

    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      a4 = VEC[i][13:10]; b4 = VEC[i][9:6]; c4 = VEC[i][5];
      @(negedge clk);
      chk({co4, s4} == {VEC[i][0], VEC[i][4:1]},
          (i == 0) ? "R6 1001+1001" : ((i >= 1 && i <= 4) ? "R3 table" : "R1 table"),
          {60'd0, co4, s4}, {60'd0, VEC[i][0], VEC[i][4:1]});
    end

    // exhaustive single slice: R1, R2, R3, R4
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [4:0] e;
          logic       t1;
          @(posedge clk);
          a4 = 4'(a); b4 = 4'(b); c4 = 1'(c);
          e  = 5'(a + b + c);
          t1 = (a4[0] & b4[0]) | ((a4[0] ^ b4[0]) & c4);
          @(negedge clk);
          chk({co4, s4} == e, "R1 sweep", {60'd0, co4, s4}, {60'd0, e});
          chk(s4[1] == (a4[1] ^ b4[1] ^ t1), "R2 bit1", {64'd0, s4[1]}, {64'd0, a4[1] ^ b4[1] ^ t1});
          if ((a4 ^ b4) == 4'hF)
            chk(co4 == c4, "R3 skip", {64'd0, co4}, {64'd0, c4});
          else
            chk(co4 == e[4], "R4 ripple", {64'd0, co4}, {64'd0, e[4]});
        end
      end
    end

    // R5 directed chains
    run64(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "R5 all-prop cin1");
    run64(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, "R5 all-prop cin0");
    run64(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, "R5 max+1");
    run64(64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0008, 1'b0, "R5 gen then skip");
    run64(64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080, 1'b0, "R5 slice edge");
    run64(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R5 all ones");
    for (int n = 0; n < 300; n++)
      run64({$urandom(), $urandom()}, {$urandom(), $urandom()}, 1'($urandom()), "R5 random");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule